// File: doc/BRIEF.md
# Sense-Offset Calibration Sequencer

This block decides when a charge gauge measures the offset of its current-sense front end, and when the stored offset value that compensates later measurements is replaced. An external timebase marks the end of each 1.28 s measurement window with a one-cycle tick. In that same cycle it presents the signed offset sample taken over the window. The sequencer does no analog work and keeps no real time of its own; it only counts ticks and routes samples.

After a full reset it runs a short quick calibration. Normally the first window only lets the supply settle and its sample is dropped; the second window's sample becomes the starting offset. A host can shorten this to one window by setting bit 0 of the control register (address 0x00) while the first window is still open. The first full calibration is then held off for 32 windows, about 40 s, and runs over four windows. The new offset is the mean of the four samples. While a full calibration runs, a status flag and a hold signal are raised, so that only capacity, voltage and temperature results keep updating. Later full calibrations start on request.

Top module: `sense_ofs_cal`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cal_busy` and `hold_upd` are 0 and `offset` is 0.
- R2: Without an early host write, the sample delivered with the first tick after reset is discarded and `offset` keeps its value. The sample delivered with the second tick is written to `offset` in the cycle after that tick.
- R3: If `host_wr` is high with `host_wdata` = 1 in any cycle from reset up to and including the first tick, the first tick's sample is written to `offset` in the next cycle and the quick calibration ends there.
- R4: A control write with `host_wdata` = 0, or any control write after the first tick, leaves the quick calibration unchanged. It still takes two windows and still uses the second sample.
- R5: `cal_busy` rises in the cycle after the 32nd tick counted after the quick calibration ends, and it stays 0 before that.
- R6: A full calibration covers exactly four ticks. `cal_busy` stays 1 until the cycle after the fourth tick, then returns to 0 unless another calibration follows.
- R7: `hold_upd` equals `cal_busy` in every cycle.
- R8: At the end of a full calibration, `offset` becomes the sum of the four samples shifted right arithmetically by 2 (rounded toward minus infinity). It is written in the cycle after the fourth tick and changes at no other time except as stated in R2 and R3.
- R9: In idle, a `recal_req` pulse starts a full calibration, and `cal_busy` is 1 in the next cycle.
- R10: A request during a full calibration is remembered and starts a new full calibration right after the current one, with no idle cycle. A request during the 32-window hold-off is absorbed by the first full calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low full reset |
| win_tick | input | 1 | One-cycle pulse at the end of each 1.28 s window |
| win_sample | input | OFS_W | Signed offset sample, valid while `win_tick` is high |
| recal_req | input | 1 | Request for a full calibration |
| host_wr | input | 1 | Host write strobe for control register 0x00 |
| host_wdata | input | 1 | Data for control bit 0 (1 = use the first window) |
| cal_busy | output | 1 | Calibration-in-progress flag |
| hold_upd | output | 1 | Hold for non-essential parameter updates |
| offset | output | OFS_W | Stored signed offset |

## Verification
The quick calibration is run three ways: with no useful host write, with bit 0 set during the first window or on its closing tick, and with bit 0 set only in the second window. This separates the "discard first window" path from the early-use path, and shows whether late or zero-valued writes are ignored. Full calibrations use mixed-sign samples and an all-negative set whose mean is not a whole number. A mistaken rounding mode or a missing sign extension in the averaging therefore shows up as a wrong offset. Requests arrive during the hold-off, during a running calibration and in idle, which tells the absorbed, back-to-back and immediate-start cases apart, while a per-cycle model fixes the exact edges of `cal_busy`.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
    typedef enum logic [2:0] {
        PH_SETTLE,
        PH_QUICK,
        PH_HOLD,
        PH_IDLE,
        PH_FULL
    } ocs_phase_e;
endpackage

// File: rtl/ocs_tick_cnt.sv
module ocs_tick_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ocs_avg_acc.sv
module ocs_avg_acc #(
    parameter int OFS_W = 16,
    parameter int SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    add,
    input  logic signed [OFS_W-1:0] sample,
    output logic signed [OFS_W-1:0] mean
);
    localparam int SW = OFS_W + SHIFT;

    logic signed [SW-1:0] sum_d, sum_q, ext, total;

    always_comb begin
        ext   = {{SHIFT{sample[OFS_W-1]}}, sample};
        total = sum_q + ext;
        mean  = OFS_W'(total >>> SHIFT);
        sum_d = sum_q;
        if (clr)
            sum_d = '0;
        else if (add)
            sum_d = total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum_q <= '0;
        else
            sum_q <= sum_d;
    end
endmodule

// File: rtl/sense_ofs_cal.sv
module sense_ofs_cal
    import ocs_pkg::*;
#(
    parameter int OFS_W      = 16,
    parameter int FULL_WIN   = 4,
    parameter int HOLD_TICKS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_tick,
    input  logic signed [OFS_W-1:0] win_sample,
    input  logic                    recal_req,
    input  logic                    host_wr,
    input  logic                    host_wdata,
    output logic                    cal_busy,
    output logic                    hold_upd,
    output logic signed [OFS_W-1:0] offset
);
    localparam int SHIFT   = $clog2(FULL_WIN);
    localparam int CNT_MAX = (HOLD_TICKS > FULL_WIN) ? HOLD_TICKS : FULL_WIN;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        ocs_phase_e              phase;
        logic                    fast;
        logic                    pend;
        logic signed [OFS_W-1:0] ofs;
    } seq_t;

    seq_t            r_q, r_d;
    logic [CW-1:0]   cnt;
    logic            fin, cnt_clr, cnt_inc, acc_clr, acc_add, early;
    logic signed [OFS_W-1:0] mean;

    ocs_tick_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    ocs_avg_acc #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
        .sample(win_sample), .mean(mean)
    );

    always_comb begin
        r_d   = r_q;
        fin   = 1'b0;
        early = r_q.fast | (host_wr & host_wdata);
        case (r_q.phase)
            PH_SETTLE: begin
                r_d.fast = early;
                if (win_tick) begin
                    if (early) begin
                        r_d.ofs   = win_sample;
                        r_d.phase = PH_HOLD;
                    end else begin
                        r_d.phase = PH_QUICK;
                    end
                end
            end
            PH_QUICK: begin
                if (win_tick) begin
                    r_d.ofs   = win_sample;
                    r_d.phase = PH_HOLD;
                end
            end
            PH_HOLD: begin
                r_d.pend = r_q.pend | recal_req;
                if (win_tick && cnt == CW'(HOLD_TICKS - 1)) begin
                    r_d.phase = PH_FULL;
                    r_d.pend  = 1'b0;
                end
            end
            PH_IDLE: begin
                if (recal_req || r_q.pend) begin
                    r_d.phase = PH_FULL;
                    r_d.pend  = 1'b0;
                end
            end
            PH_FULL: begin
                r_d.pend = r_q.pend | recal_req;
                if (win_tick && cnt == CW'(FULL_WIN - 1)) begin
                    fin     = 1'b1;
                    r_d.ofs = mean;
                    if (r_q.pend || recal_req)
                        r_d.pend = 1'b0;
                    else
                        r_d.phase = PH_IDLE;
                end
            end
            default: r_d.phase = PH_SETTLE;
        endcase
        cnt_clr = (r_d.phase != r_q.phase) | fin;
        cnt_inc = win_tick & ((r_q.phase == PH_HOLD) | (r_q.phase == PH_FULL));
        acc_clr = (r_q.phase != PH_FULL) | fin;
        acc_add = win_tick & (r_q.phase == PH_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase <= PH_SETTLE;
            r_q.fast  <= 1'b0;
            r_q.pend  <= 1'b0;
            r_q.ofs   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cal_busy = (r_q.phase == PH_FULL);
    assign hold_upd = (r_q.phase == PH_FULL);
    assign offset   = r_q.ofs;

    // R8
    ofs_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset) |-> $past(win_tick));

    // R6
    busy_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> $past(win_tick));

    // R5
    hold_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_HOLD) |-> (cnt < CW'(HOLD_TICKS)));

    // R6
    full_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_FULL) |-> (cnt < CW'(FULL_WIN)));

    // R9
    busy_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> ($past(win_tick) || $past(recal_req) || $past(r_q.pend)));
endmodule

// File: tb/sense_ofs_cal_tb.sv
module sense_ofs_cal_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_tick = 1'b0;
    logic signed [15:0] win_sample = '0;
    logic recal_req = 1'b0;
    logic host_wr = 1'b0;
    logic host_wdata = 1'b0;
    logic cal_busy, hold_upd;
    logic signed [15:0] offset;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_ph = 0;   // 0 settle, 1 second window, 2 hold-off, 3 idle, 4 full
    int m_cnt = 0;
    bit m_fast = 0;
    bit m_pend = 0;
    int m_ofs = 0;
    int m_q[$];

    always #2.5 clk = ~clk;

    sense_ofs_cal u_dut (
        .clk(clk), .rst_n(rst_n), .win_tick(win_tick), .win_sample(win_sample),
        .recal_req(recal_req), .host_wr(host_wr), .host_wdata(host_wdata),
        .cal_busy(cal_busy), .hold_upd(hold_upd), .offset(offset)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_fast = 0; m_pend = 0; m_ofs = 0; m_q.delete();
        end else begin
            case (m_ph)
                0: begin
                    if (host_wr && host_wdata) m_fast = 1;
                    if (win_tick) begin
                        if (m_fast) begin m_ofs = win_sample; m_ph = 2; m_cnt = 0; end
                        else m_ph = 1;
                    end
                end
                1: if (win_tick) begin m_ofs = win_sample; m_ph = 2; m_cnt = 0; end
                2: begin
                    if (recal_req) m_pend = 1;
                    if (win_tick) begin
                        m_cnt++;
                        if (m_cnt == 32) begin m_ph = 4; m_pend = 0; m_q.delete(); end
                    end
                end
                3: if (recal_req || m_pend) begin m_ph = 4; m_pend = 0; m_q.delete(); end
                default: begin
                    if (recal_req) m_pend = 1;
                    if (win_tick) begin
                        m_q.push_back(int'(win_sample));
                        if (m_q.size() == 4) begin
                            int s;
                            s = 0;
                            foreach (m_q[i]) s += m_q[i];
                            m_ofs = s >>> 2;
                            m_q.delete();
                            if (m_pend) m_pend = 0;
                            else m_ph = 3;
                        end
                    end
                end
            endcase
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (cal_busy !== (m_ph == 4) || hold_upd !== (m_ph == 4) ||
                int'(offset) != m_ofs) begin
                errors++;
                $display("FAIL %s cycle %0d: busy=%0b hold=%0b ofs=%0d expected busy=%0b hold=%0b ofs=%0d",
                         cur_req, cycles, cal_busy, hold_upd, offset, (m_ph == 4), (m_ph == 4), m_ofs);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc(input bit t, input int s, input bit rq, input bit w, input bit b);
        win_tick = t; win_sample = s[15:0]; recal_req = rq; host_wr = w; host_wdata = b;
        @(negedge clk);
    endtask

    task automatic win(input int s);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(1, s, 0, 0, 0);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1";
        do_reset();
        chk("R1", int'(cal_busy), 0);
        chk("R1", int'(hold_upd), 0);
        chk("R1", int'(offset), 0);

        // two-window quick calibration, writes that must not shorten it
        cur_req = "R4";
        cyc(0, 0, 0, 1, 0);
        cyc(1, 100, 0, 0, 0);
        chk("R2", int'(offset), 0);
        cyc(0, 0, 0, 1, 1);
        cyc(1, -37, 0, 0, 0);
        chk("R2", int'(offset), -37);
        chk("R4", int'(offset), -37);

        // hold-off with an absorbed request
        cur_req = "R5";
        for (int i = 1; i <= 31; i++) begin
            if (i == 10) cyc(0, 0, 1, 0, 0);
            win(7);
        end
        chk("R5", int'(cal_busy), 0);
        chk("R8", int'(offset), -37);
        win(7);
        chk("R5", int'(cal_busy), 1);
        chk("R7", int'(hold_upd), 1);

        // full calibration with mixed signs and a queued request
        cur_req = "R10";
        win(10);
        cyc(0, 0, 1, 0, 0);
        win(11);
        win(-3);
        chk("R8", int'(offset), -37);
        chk("R6", int'(cal_busy), 1);
        win(5);
        chk("R8", int'(offset), 5);
        chk("R10", int'(cal_busy), 1);

        cur_req = "R8";
        win(-1); win(-2); win(-2); win(-2);
        chk("R8", int'(offset), -2);
        chk("R6", int'(cal_busy), 0);
        cyc(0, 0, 0, 0, 0);
        chk("R10", int'(cal_busy), 0);

        cur_req = "R9";
        cyc(0, 0, 1, 0, 0);
        chk("R9", int'(cal_busy), 1);
        win(400); win(400); win(401); win(401);
        chk("R8", int'(offset), 400);
        chk("R6", int'(cal_busy), 0);

        // early host write during the first window
        cur_req = "R3";
        do_reset();
        cyc(0, 0, 0, 1, 1);
        cyc(1, 77, 0, 0, 0);
        chk("R3", int'(offset), 77);
        win(5);
        chk("R3", int'(offset), 77);

        // host write on the closing tick of the first window
        do_reset();
        cyc(1, -12, 0, 1, 1);
        chk("R3", int'(offset), -12);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule